// File: doc/BRIEF.md
# Serial-in shift register with output latch

The block accepts a serial bit stream and presents it as a parallel word. Bits enter the first stage of a shift chain on each rising edge of a shift clock and move one stage along per edge. A second, independent storage clock takes a snapshot of the whole chain into a holding register. That register drives the parallel outputs only while an active-low output enable is asserted, and the outputs float otherwise. The last stage of the chain is brought out as a cascade bit, so several copies can be wired in series and loaded from one serial line.

An active-low asynchronous clear empties the shift chain only; the holding register keeps its value and powers up at zero. When the two clocks are tied together, the holding register always captures the chain as it was before that edge's shift, so it runs one pulse behind.

The design has no state machine: it is three register or driver slices joined under one top.

Top module: `sipo_latch_top`

## Requirements
- R1: On each rising edge of `shift_clk` with `clear_n` high, stage 0 takes `ser_in` and every stage k (k ≥ 1) takes the previous value of stage k-1.
- R2: `cascade_out` always equals the last shift stage; in a chain of two copies, 16 serial bits appear on the combined parallel outputs, the first bit sent at the most significant position of the far copy.
- R3: On each rising edge of `store_clk`, all shift stages are copied at once into the holding register, bit k of `held_q` and `par_out` coming from stage k.
- R4: A low level on `clear_n` zeroes every shift stage and `cascade_out` at once, without any clock edge, and leaves the holding register unchanged.
- R5: While `out_en_n` is 0, `par_out` equals the holding register; while it is 1, every bit of `par_out` is high-impedance ('z').
- R6: When both clocks rise on the same edge, the holding register receives the chain contents from before that edge's shift.
- R7: A `store_clk` edge while `clear_n` is low loads all zeros into the holding register.
- R8: `out_en_n` has no effect on `cascade_out` or on the holding register.
- R9: Before the first `store_clk` edge, the holding register is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, rising edge active |
| store_clk | input | 1 | Storage clock, rising edge active |
| clear_n | input | 1 | Asynchronous clear of the shift chain, active low |
| out_en_n | input | 1 | Parallel output enable, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_out | output | STAGES | Parallel outputs, 'z' when disabled |
| held_q | output | STAGES | Holding register contents, always driven |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
On every shift edge the assertions confirm that the chain moved by exactly one place with the serial bit at the front, that the cascade bit is zero while clear is held, and that enabled outputs match the holding register; on every storage edge they confirm the snapshot equals the chain sampled at the previous storage edge. What only the scenarios can show is the ordering between the two clocks when they rise together, the asynchronous effect of clear between edges, the high-impedance state, the zero power-up value, and the 16-bit result through two chained copies, all compared against a behavioural bit-queue model after every pulse.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int unsigned DEFAULT_STAGES = 8;

    typedef enum logic {
        DRV_FLOAT = 1'b0,
        DRV_ACTIVE = 1'b1
    } drv_mode_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned STAGES = sipo_pkg::DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              din,
    output logic [STAGES-1:0] stages,
    output logic              tail
);
    localparam int unsigned LAST = STAGES - 1;

    // stage 0 takes the serial input, the rest take their neighbour
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic nxt;
        if (g == 0) begin : g_head
            assign nxt = din;
        end else begin : g_body
            assign nxt = stages[g-1];
        end
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                stages[g] <= 1'b0;
            end else begin
                stages[g] <= nxt;
            end
        end
    end

    assign tail = stages[LAST];

    // R1: chain advances by one place per edge with the serial bit at the front
    a_r1_shift_one_place: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> (stages[0] == $past(din)) &&
                 (stages[LAST:1] == $past(stages[LAST-1:0])));
endmodule

// File: rtl/sipo_hold_bank.sv
module sipo_hold_bank #(
    parameter int unsigned STAGES = sipo_pkg::DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [STAGES-1:0] snap,
    output logic [STAGES-1:0] bank
);
    // no reset of its own; power-up value is zero
    logic [STAGES-1:0] held = '0;

    always_ff @(posedge clk) begin
        held <= snap;
    end

    assign bank = held;

    // R3: what the bank holds after an edge is the chain sampled at that edge
    a_r3_snapshot: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> bank == $past(snap));
endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
    parameter int unsigned STAGES = sipo_pkg::DEFAULT_STAGES
) (
    input  logic              en_n,
    input  logic [STAGES-1:0] value,
    output logic [STAGES-1:0] pins
);
    import sipo_pkg::*;

    drv_mode_e mode;

    assign mode = en_n ? DRV_FLOAT : DRV_ACTIVE;
    assign pins = (mode == DRV_ACTIVE) ? value : {STAGES{1'bz}};
endmodule

// File: rtl/sipo_latch_top.sv
module sipo_latch_top #(
    parameter int unsigned STAGES = sipo_pkg::DEFAULT_STAGES
) (
    input  logic              shift_clk,
    input  logic              store_clk,
    input  logic              clear_n,
    input  logic              out_en_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] par_out,
    output logic [STAGES-1:0] held_q,
    output logic              cascade_out
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] bank_q;

    sipo_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk    (shift_clk),
        .clr_n  (clear_n),
        .din    (ser_in),
        .stages (chain_q),
        .tail   (cascade_out)
    );

    sipo_hold_bank #(.STAGES(STAGES)) u_bank (
        .clk   (store_clk),
        .clr_n (clear_n),
        .snap  (chain_q),
        .bank  (bank_q)
    );

    sipo_out_drv #(.STAGES(STAGES)) u_drv (
        .en_n  (out_en_n),
        .value (bank_q),
        .pins  (par_out)
    );

    assign held_q = bank_q;

    // R4: while clear is held, the cascade bit reads zero
    a_r4_clear_cascade: assert property (@(posedge shift_clk) disable iff (clear_n)
        1'b1 |-> cascade_out == 1'b0);

    // R5: enabled outputs show the holding register
    a_r5_enabled_follow: assert property (@(posedge shift_clk) disable iff (!clear_n)
        !out_en_n |-> par_out == held_q);
endmodule

// File: tb/sipo_latch_top_tb_top.sv
module sipo_latch_top_tb_top;
    localparam int unsigned W = 8;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned Q = CLK_PERIOD / 4;

    logic shift_clk = 1'b0;
    logic store_clk = 1'b0;
    logic clear_n = 1'b0;
    logic out_en_n = 1'b1;
    logic ser_in = 1'b0;
    logic [W-1:0] par_a, par_b, held_a, held_b;
    logic casc_a, casc_b;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference: bit 0 of each array is stage 0 of the near copy
    bit ref_chain [2*W];
    bit ref_hold [2*W];

    sipo_latch_top #(.STAGES(W)) dut_i (
        .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n),
        .out_en_n(out_en_n), .ser_in(ser_in), .par_out(par_a),
        .held_q(held_a), .cascade_out(casc_a));

    sipo_latch_top #(.STAGES(W)) dut_far (
        .shift_clk(shift_clk), .store_clk(store_clk), .clear_n(clear_n),
        .out_en_n(out_en_n), .ser_in(casc_a), .par_out(par_b),
        .held_q(held_b), .cascade_out(casc_b));

    function automatic logic [2*W-1:0] ref_hold_vec();
        logic [2*W-1:0] v;
        for (int k = 0; k < 2*W; k++) v[k] = ref_hold[k];
        return v;
    endfunction

    task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        logic [2*W-1:0] exp_par;
        exp_par = out_en_n ? {2*W{1'bz}} : ref_hold_vec();
        chk({req, " cascade"}, {14'd0, casc_b, casc_a},
            {14'd0, 1'(ref_chain[2*W-1]), 1'(ref_chain[W-1])});
        chk({req, " held"}, {held_b, held_a}, ref_hold_vec());
        chk({req, " par_out"}, {par_b, par_a}, exp_par);
    endtask

    // one pulse on either or both clocks, then compare
    task automatic pulse(input bit do_shift, input bit do_store, input bit d, input string req);
        bit old [2*W];
        ser_in = d;
        #Q;
        old = ref_chain;
        if (do_store) ref_hold = clear_n ? old : '{default: 1'b0};
        if (do_shift && clear_n) begin
            ref_chain[0] = d;
            for (int k = 1; k < 2*W; k++) ref_chain[k] = old[k-1];
        end
        shift_clk = do_shift;
        store_clk = do_store;
        #Q;
        shift_clk = 1'b0;
        store_clk = 1'b0;
        #Q;
        compare_all(req);
        #Q;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [2*W-1:0] word;
        ref_chain = '{default: 1'b0};
        ref_hold = '{default: 1'b0};
        #(CLK_PERIOD);
        // R9 / R5: power-up zero, outputs floating while disabled
        compare_all("R9 R5 reset");
        clear_n = 1'b1;
        out_en_n = 1'b0;
        #(CLK_PERIOD);
        compare_all("R9 power-up zero enabled");

        // R1, R2: shift 16 bits, store once, read combined word
        word = 16'hB4E1;
        for (int i = 2*W-1; i >= 0; i--) pulse(1'b1, 1'b0, word[i], "R1 shift");
        compare_all("R2 cascade after fill");
        pulse(1'b0, 1'b1, 1'b0, "R3 store");
        chk("R2 chained word", {par_b, par_a}, word);

        // R3: storage unchanged by shifts without store edge
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0, i[0], "R3 hold between stores");

        // R6: tied clocks
        for (int i = 0; i < 6; i++) pulse(1'b1, 1'b1, ~i[1], "R6 tied clocks");

        // R8: disable outputs, cascade and held keep working
        out_en_n = 1'b1;
        #Q;
        compare_all("R5 disabled float");
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0, 1'b1, "R8 shift while disabled");
        pulse(1'b0, 1'b1, 1'b0, "R8 store while disabled");
        out_en_n = 1'b0;
        #Q;
        compare_all("R5 re-enabled");

        // R4: asynchronous clear mid-cycle, storage kept
        for (int i = 0; i < 8; i++) pulse(1'b1, 1'b0, 1'b1, "R4 prefill");
        clear_n = 1'b0;
        #1;
        ref_chain = '{default: 1'b0};
        compare_all("R4 async clear");
        pulse(1'b1, 1'b0, 1'b1, "R4 shift ignored during clear");

        // R7: store during clear loads zeros
        pulse(1'b0, 1'b1, 1'b0, "R7 store during clear");
        clear_n = 1'b1;
        #Q;
        compare_all("R7 after release");

        // R1 again with alternating pattern
        for (int i = 0; i < 2*W; i++) pulse(1'b1, 1'b0, i[0] ^ i[2], "R1 pattern");
        pulse(1'b0, 1'b1, 1'b0, "R3 final store");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule